// File: doc/BRIEF.md
# Four-Way True LRU Recency Tracker

This block keeps the exact recency order of the four ways of one cache set. The order is held as six pairwise flags. Each flag records which bank of one pair was touched more recently. When a reference strobe arrives with a two-bit bank index, the referenced bank becomes the most recent of the four. The relative order of the other three banks does not change.

The block drives the index of the least recently used bank from the stored flags at all times. A cache controller can use this index as its replacement victim. The controller pulses the strobe on every hit or fill of the set.

The next-state logic depends only on the six flags and the two-bit index, so it is equivalent to a 256-entry table of six-bit words. The victim decode depends only on the six flags, so it is equivalent to a 64-entry table of two-bit words. Both are written as computed logic rather than stored tables.

A consistency monitor raises a flag whenever the six bits do not describe a total order. Only 24 of the 64 codes describe one.

Top module: `lru4_tracker`

## Requirements
- R1: After reset the six-bit order code is all ones, meaning banks 0, 1, 2, 3 from least to most recent, so `lru_bank` reads 0.
- R2: The order code has one bit per bank pair (lo, hi) with lo < hi, at bit position hi*(hi-1)/2 + lo. The pairs are placed as follows: (0,1) at bit 0, (0,2) at bit 1, (1,2) at bit 2, (0,3) at bit 3, (1,3) at bit 4 and (2,3) at bit 5. A bit value of 1 means bank hi was used more recently than bank lo.
- R3: A clock edge with `ref_valid` high makes `ref_bank` the most recent bank. From the following cycle on, `lru_bank` never names that bank until another bank has been referenced.
- R4: A reference keeps the relative order of the three banks that were not referenced. A reference to any bank other than the current LRU therefore leaves `lru_bank` unchanged.
- R5: A clock edge with `ref_valid` low leaves the order unchanged, whatever value `ref_bank` carries.
- R6: `lru_bank` names the one bank that every other bank is marked as more recent than.
- R7: Referencing the bank that is already the most recent leaves the order unchanged.
- R8: `lru_bank` is decoded from registered state only. It changes exactly one clock edge after the reference that causes the change.
- R9: `order_bad` is high whenever the stored code is one of the 40 codes that do not describe a total order. It stays low in every state the block can reach from reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_valid | input | 1 | Reference strobe for this set |
| ref_bank | input | 2 | Index of the referenced bank |
| lru_bank | output | 2 | Index of the least recently used bank |
| order_bad | output | 1 | Stored code is not a legal ordering |

## Verification
Two functions can fall in the same cycle: a reference that updates the order, and the victim report that the controller reads in that cycle. The interesting case is a reference aimed at the bank `lru_bank` currently names, because the reported victim must then move to the next-oldest bank on that same edge. The bench provokes this by reading `lru_bank` and referencing that bank straight away, over many back-to-back edges. It also mixes in random traces, idle cycles that carry junk indices, and repeated hits to the most recent bank. Each result is judged against a reference list ordered from least to most recent, one cycle after the edge.

// File: rtl/lru4_pkg.sv
package lru4_pkg;

    localparam int LRU_WAYS = 4;

    // Bit position of the pair flag for banks lo < hi.
    function automatic int pair_pos(input int lo, input int hi);
        return (hi * (hi - 1)) / 2 + lo;
    endfunction

endpackage

// File: rtl/lru4_order_update.sv
module lru4_order_update
    import lru4_pkg::*;
#(
    parameter int NW = LRU_WAYS,
    localparam int BW = $clog2(NW),
    localparam int PW = NW * (NW - 1) / 2
) (
    input  logic [PW-1:0] order_cur,
    input  logic [BW-1:0] touch_bank,
    output logic [PW-1:0] order_nxt
);

    for (genvar hi = 1; hi < NW; hi++) begin : g_hi
        for (genvar lo = 0; lo < hi; lo++) begin : g_lo
            localparam int P = pair_pos(lo, hi);
            always_comb begin
                if (touch_bank == BW'(hi))
                    order_nxt[P] = 1'b1;
                else if (touch_bank == BW'(lo))
                    order_nxt[P] = 1'b0;
                else
                    order_nxt[P] = order_cur[P];
            end
        end
    end

endmodule

// File: rtl/lru4_victim_pick.sv
module lru4_victim_pick
    import lru4_pkg::*;
#(
    parameter int NW = LRU_WAYS,
    localparam int BW = $clog2(NW),
    localparam int PW = NW * (NW - 1) / 2
) (
    input  logic [PW-1:0] order_cur,
    output logic [BW-1:0] victim
);

    logic [NW-1:0] is_oldest;

    for (genvar i = 0; i < NW; i++) begin : g_way
        always_comb begin
            is_oldest[i] = 1'b1;
            for (int j = 0; j < NW; j++) begin
                if (j > i)
                    is_oldest[i] = is_oldest[i] & order_cur[pair_pos(i, j)];
                else if (j < i)
                    is_oldest[i] = is_oldest[i] & ~order_cur[pair_pos(j, i)];
            end
        end
    end

    always_comb begin
        victim = '0;
        for (int i = NW - 1; i >= 0; i--) begin
            if (is_oldest[i])
                victim = BW'(i);
        end
    end

endmodule

// File: rtl/lru4_order_check.sv
module lru4_order_check
    import lru4_pkg::*;
#(
    parameter int NW = LRU_WAYS,
    localparam int BW = $clog2(NW),
    localparam int PW = NW * (NW - 1) / 2
) (
    input  logic [PW-1:0] order_cur,
    output logic          not_total
);

    logic [BW-1:0] wins [NW];

    always_comb begin
        for (int i = 0; i < NW; i++) begin
            wins[i] = '0;
            for (int j = 0; j < NW; j++) begin
                if (j > i && !order_cur[pair_pos(i, j)])
                    wins[i] = wins[i] + BW'(1);
                else if (j < i && order_cur[pair_pos(j, i)])
                    wins[i] = wins[i] + BW'(1);
            end
        end
    end

    always_comb begin
        not_total = 1'b0;
        for (int i = 0; i < NW; i++)
            for (int j = i + 1; j < NW; j++)
                if (wins[i] == wins[j])
                    not_total = 1'b1;
    end

endmodule

// File: rtl/lru4_tracker.sv
module lru4_tracker
    import lru4_pkg::*;
#(
    parameter int NW = LRU_WAYS,
    localparam int BW = $clog2(NW),
    localparam int PW = NW * (NW - 1) / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ref_valid,
    input  logic [BW-1:0] ref_bank,
    output logic [BW-1:0] lru_bank,
    output logic          order_bad
);

    typedef struct packed {
        logic [PW-1:0] order;
    } track_t;

    track_t        st_d, st_q;
    logic [PW-1:0] order_upd;

    lru4_order_update #(.NW(NW)) upd_i (
        .order_cur (st_q.order),
        .touch_bank(ref_bank),
        .order_nxt (order_upd)
    );

    lru4_victim_pick #(.NW(NW)) pick_i (
        .order_cur(st_q.order),
        .victim   (lru_bank)
    );

    lru4_order_check #(.NW(NW)) chk_i (
        .order_cur(st_q.order),
        .not_total(order_bad)
    );

    always_comb begin
        st_d = st_q;
        if (ref_valid)
            st_d.order = order_upd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '{order: '1};
        else
            st_q <= st_d;
    end

    // R3
    touched_not_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_valid |=> lru_bank != $past(ref_bank));

    // R4
    other_keeps_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_valid && ref_bank != lru_bank) |=> lru_bank == $past(lru_bank));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_valid |=> $stable(st_q.order));

    // R9
    legal_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !order_bad);

endmodule

// File: tb/lru4_tracker_tb_top.sv
module lru4_tracker_tb_top;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [1:0] lru;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_valid = 1'b0;
    logic [1:0] ref_bank = '0;
    logic [1:0] lru_bank;
    logic       order_bad;

    int   n_cmp = 0;
    int   n_bad = 0;
    exp_t sb_q[$];
    int   model[$];
    bit   done = 1'b0;

    lru4_tracker dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_valid(ref_valid),
        .ref_bank (ref_bank),
        .lru_bank (lru_bank),
        .order_bad(order_bad)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Driver: one edge per call, model updated, expectation queued.
    task automatic step(input bit v, input logic [1:0] b, input string tag);
        @(negedge clk);
        ref_valid = v;
        ref_bank  = b;
        @(posedge clk);
        #1;
        if (v) begin
            foreach (model[i]) begin
                if (model[i] == int'(b)) begin
                    model.delete(i);
                    break;
                end
            end
            model.push_back(int'(b));
        end
        sb_q.push_back('{lru: 2'(model[0]), tag: tag});
    endtask

    // Monitor: compare at the negedge after each edge.
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_cmp++;
                if (lru_bank !== e.lru) begin
                    n_bad++;
                    $display("FAIL %s lru_bank actual=%0d expected=%0d", e.tag, lru_bank, e.lru);
                end
                n_cmp++;
                if (order_bad !== 1'b0) begin
                    n_bad++;
                    $display("FAIL R9 order_bad actual=%b expected=0", order_bad);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        model = '{0, 1, 2, 3};
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state: all-ones code, bank 0 oldest
        step(1'b0, 2'd0, "R1");
        // R2 / R6 walk: each single reference exercises one group of pair bits
        step(1'b1, 2'd0, "R2");
        step(1'b1, 2'd2, "R2");
        step(1'b1, 2'd1, "R6");
        step(1'b1, 2'd3, "R6");
        // R7 repeated hit to the most recent bank
        for (int k = 0; k < 4; k++) step(1'b1, 2'd3, "R7");
        // R5 idle edges carrying junk indices
        for (int k = 0; k < 8; k++) step(1'b0, 2'(k), "R5");
        // R4 references to non-victim banks
        for (int k = 0; k < 20; k++) begin
            logic [1:0] b;
            b = 2'(model[1 + ($urandom % 3)]);
            step(1'b1, b, "R4");
        end
        // R3 / R8 always hit the reported victim on the same cycle it is read
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            step(1'b1, lru_bank, "R3");
        end
        // R8 random traces with idle gaps
        for (int k = 0; k < 3000; k++) begin
            step(($urandom % 4) != 0, 2'($urandom % 4), "R8");
        end
        // R1 again: ordering 0,1,2,3 gives the same state as reset
        for (int k = 0; k < 4; k++) step(1'b1, 2'(k), "R1");
        // R1 reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model = '{0, 1, 2, 3};
        step(1'b0, 2'd2, "R1");
        wait (sb_q.size() == 0);
        @(negedge clk);
        @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule